// File: doc/BRIEF.md
# Saturating Line-Violation Counter Bank

This block keeps one error counter for each of eight receive channels. Every cycle in which a channel's violation input is high, that channel's counter goes up by one. A counter that reaches its largest value stays there and does not wrap. The violation pulses come from a detector outside this block.

A host takes a snapshot with an update strobe. The strobe can act on all channels at once or on one channel only. It copies each affected counter into that channel's holding register and starts a new counting period. A clear strobe, global or per channel, sets the live counter to zero.

The host reads a snapshot one byte at a time. It puts a channel address on the read port and uses a byte-select input to choose the low or high byte. Each channel also drives a status flag. In live mode the flag shows the channel's current violation activity. In counter-monitor mode it shows that the channel's counter has saturated.

Top module: `lcv_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, every holding register and the read data are zero.
- R2: Each clock cycle in which a channel's violation input is high adds exactly one to that channel's counter.
- R3: A counter that reaches 65535 (all ones) stays at 65535 while violations continue, until it is cleared.
- R4: A clear, global or for one channel, sets the counter to zero and wins over a coincident violation and a coincident update. A coincident update still copies the value the counter held before the clear. A clear alone leaves the holding register unchanged.
- R5: An update, global or for one channel, copies the counter into the holding register. The counter then restarts at 0, or at 1 if a violation arrives in the same cycle as the update.
- R6: A per-channel violation, clear or update affects only the channel it names.
- R7: Read data is registered. One clock after an address and byte-select are applied, the read data holds bits 7:0 of that channel's holding register when byte-select is 0, and bits 15:8 when byte-select is 1.
- R8: When the mode input is 0, each status flag equals that channel's live-activity input.
- R9: When the mode input is 1, each status flag is 1 exactly when that channel's counter equals 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| viol_i | input | 8 | Violation pulse, one bit per channel |
| live_i | input | 8 | Live violation/excess-zero activity, one bit per channel |
| clr_all_i | input | 1 | Clear all counters |
| clr_ch_i | input | 8 | Clear one channel's counter |
| upd_all_i | input | 1 | Snapshot all counters |
| upd_ch_i | input | 8 | Snapshot one channel's counter |
| mon_mode_i | input | 1 | 0: flags show live activity; 1: flags show saturation |
| rd_addr_i | input | 3 | Channel selected for readback |
| byte_sel_i | input | 1 | 0: low byte; 1: high byte |
| rd_data_o | output | 8 | Registered readback byte |
| flag_o | output | 8 | Per-channel status flag |

## Verification
A counter that holds a wrong value stays hidden until the next snapshot is read back. It shows up two cycles after the update strobe (one for the copy, one for the read register), or at once on the flag in monitor mode if the fault is in saturation. Wrong strobe priority or a wrong restart value shows up in the snapshot taken after the coincident cycle. A byte swap or a wrong channel decode shows up in the byte read back one cycle after the address is applied.

// File: rtl/lcvb_pkg.sv
// Package for the counter bank: flag-mode encoding and a saturating
// increment helper. Assumes counter widths of 2 bits or more.
package lcvb_pkg;

    typedef enum logic {
        FLAG_LIVE = 1'b0,
        FLAG_SAT  = 1'b1
    } flag_mode_e;

    // Add one unless already at all ones.
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max);
        return (v == max) ? v : v + 32'd1;
    endfunction

endpackage

// File: rtl/lcvb_chan_counter.sv
// One channel: saturating violation counter, snapshot holding register
// and status flag select. Assumes the clear and update inputs are already
// merged from the global and per-channel strobes. Clear outranks update,
// and update outranks increment.
module lcvb_chan_counter
    import lcvb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol_i,
    input  logic             live_i,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic             mon_mode_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;
    logic             sat;
    logic [31:0]      inc_val;

    assign sat     = (cnt_q == CNT_MAX);
    assign inc_val = sat_inc(32'(cnt_q), 32'(CNT_MAX));

    // Counter: clear, else restart on update, else saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (upd_i)  cnt_q <= {{(CNT_W-1){1'b0}}, viol_i};
        else if (viol_i) cnt_q <= inc_val[CNT_W-1:0];
    end

    // Holding register: take the pre-update counter value on update.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (upd_i) hold_q <= cnt_q;
    end

    // Flag: live activity or saturation, chosen by mode.
    always_comb begin
        flag_o = (flag_mode_e'(mon_mode_i) == FLAG_SAT) ? sat : live_i;
    end

    assign hold_o = hold_q;

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);

    // R5
    snapshot_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> hold_q == $past(cnt_q));

    // R5
    restart_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i) |=> cnt_q == CNT_W'($past(viol_i)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_i && !clr_i && !upd_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R3
    stay_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i && !upd_i) |=> cnt_q == CNT_MAX);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_i && !clr_i && !upd_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lcvb_read_mux.sv
// Indirect byte readback: picks one channel's holding register by address,
// then its low or high byte, and registers the byte (one cycle of latency).
// Assumes the holding registers are packed with channel 0 at the bottom.
module lcvb_read_mux #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0][CNT_W-1:0] hold_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        byte_sel_i,
    output logic [BYTE_W-1:0]           data_o
);
    logic [CNT_W-1:0]  word;
    logic [BYTE_W-1:0] byte_nxt;

    // Select the addressed channel; an out-of-range address reads zero.
    always_comb begin
        word = '0;
        if (int'(addr_i) < NUM_CH) word = hold_i[addr_i];
        byte_nxt = byte_sel_i ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
    end

    // Register the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) data_o <= '0;
        else        data_o <= byte_nxt;
    end

    // R7
    byte_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) < NUM_CH) |=> data_o == ($past(byte_sel_i)
            ? $past(hold_i[addr_i][2*BYTE_W-1:BYTE_W])
            : $past(hold_i[addr_i][BYTE_W-1:0])));

endmodule

// File: rtl/lcv_counter_bank.sv
// Top of the violation counter bank: one counter channel per line, merged
// global and per-channel strobes, and a registered indirect byte readback.
// Assumes CNT_W equals two bytes.
module lcv_counter_bank #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] viol_i,
    input  logic [NUM_CH-1:0] live_i,
    input  logic              clr_all_i,
    input  logic [NUM_CH-1:0] clr_ch_i,
    input  logic              upd_all_i,
    input  logic [NUM_CH-1:0] upd_ch_i,
    input  logic              mon_mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              byte_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [NUM_CH-1:0] flag_o
);
    logic [NUM_CH-1:0][CNT_W-1:0] hold;

    // One counter channel per line, with the global and local strobes merged.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        lcvb_chan_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .viol_i     (viol_i[g]),
            .live_i     (live_i[g]),
            .clr_i      (clr_all_i | clr_ch_i[g]),
            .upd_i      (upd_all_i | upd_ch_i[g]),
            .mon_mode_i (mon_mode_i),
            .hold_o     (hold[g]),
            .flag_o     (flag_o[g])
        );
    end

    lcvb_read_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .addr_i     (rd_addr_i),
        .byte_sel_i (byte_sel_i),
        .data_o     (rd_data_o)
    );

    // R8
    live_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_mode_i |-> flag_o == live_i);

endmodule

// File: tb/lcv_counter_bank_bench.sv
`timescale 1ns/1ps
module lcv_counter_bank_bench;
    localparam int NCH = 8;
    localparam int NV  = 7;
    localparam int VEC_CH  [NV] = '{0, 1, 2, 3, 4, 5, 6};
    localparam int VEC_N   [NV] = '{0, 1, 7, 255, 256, 513, 4660};
    localparam int VEC_EXP [NV] = '{0, 1, 7, 255, 256, 513, 4660};

    logic clk = 0;
    logic rst_n = 0;
    logic [NCH-1:0] viol = '0, live = '0, clr_ch = '0, upd_ch = '0, flag;
    logic clr_all = 0, upd_all = 0, mode = 0, bsel = 0;
    logic [2:0] addr = '0;
    logic [7:0] rdata;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcv_counter_bank u_lcv_counter_bank (
        .clk(clk), .rst_n(rst_n), .viol_i(viol), .live_i(live),
        .clr_all_i(clr_all), .clr_ch_i(clr_ch), .upd_all_i(upd_all),
        .upd_ch_i(upd_ch), .mon_mode_i(mode), .rd_addr_i(addr),
        .byte_sel_i(bsel), .rd_data_o(rdata), .flag_o(flag));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int ch, input int n);
        if (n == 0) return;
        viol[ch] = 1'b1;
        repeat (n) @(negedge clk);
        viol[ch] = 1'b0;
    endtask

    task automatic strobe_upd(input int ch);
        upd_ch[ch] = 1'b1;
        @(negedge clk);
        upd_ch[ch] = 1'b0;
    endtask

    task automatic strobe_clr_all();
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    // Read the 16-bit snapshot as two bytes, each one clock after it is addressed.
    task automatic rd_word(input int ch, output int w);
        logic [7:0] lo;
        addr = 3'(ch); bsel = 1'b0;
        @(negedge clk);
        lo = rdata;
        bsel = 1'b1;
        @(negedge clk);
        w = {rdata, lo};
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1: reset state, all snapshots zero and live flags zero
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            rd_word(c, w);
            chk("R1 reset snapshot", w, 0);
        end
        chk("R1 reset flags", int'(flag), 0);

        // R2/R7: table of pulse counts, read back through both bytes
        for (int i = 0; i < NV; i++) begin
            strobe_clr_all();
            pulse(VEC_CH[i], VEC_N[i]);
            strobe_upd(VEC_CH[i]);
            rd_word(VEC_CH[i], w);
            chk("R2 R7 count readback", w, VEC_EXP[i]);
        end

        // R7: byte select on a known value 4660 = 0x1234
        addr = 3'd6; bsel = 1'b1;
        @(negedge clk);
        chk("R7 high byte", int'(rdata), 8'h12);
        bsel = 1'b0;
        @(negedge clk);
        chk("R7 low byte", int'(rdata), 8'h34);

        // R5: update with coincident violation restarts at 1
        strobe_clr_all();
        pulse(0, 3);
        viol[0] = 1'b1; upd_ch[0] = 1'b1;
        @(negedge clk);
        viol[0] = 1'b0; upd_ch[0] = 1'b0;
        rd_word(0, w);
        chk("R5 snapshot before restart", w, 3);
        strobe_upd(0);
        rd_word(0, w);
        chk("R5 restart counts violation", w, 1);

        // R4: clear with coincident update and violation
        pulse(1, 9);
        clr_ch[1] = 1'b1; upd_ch[1] = 1'b1; viol[1] = 1'b1;
        @(negedge clk);
        clr_ch[1] = 1'b0; upd_ch[1] = 1'b0; viol[1] = 1'b0;
        rd_word(1, w);
        chk("R4 update beside clear copies old value", w, 9);
        strobe_upd(1);
        rd_word(1, w);
        chk("R4 clear wins over increment", w, 0);

        // R4: clear alone keeps the snapshot
        pulse(2, 4);
        strobe_upd(2);
        clr_ch[2] = 1'b1;
        @(negedge clk);
        clr_ch[2] = 1'b0;
        rd_word(2, w);
        chk("R4 clear keeps snapshot", w, 4);

        // R6: channel independence
        strobe_clr_all();
        pulse(2, 6);
        upd_all = 1'b1;
        @(negedge clk);
        upd_all = 1'b0;
        rd_word(5, w);
        chk("R6 untouched channel", w, 0);
        pulse(2, 5);
        pulse(3, 2);
        strobe_upd(3);
        rd_word(2, w);
        chk("R6 other snapshot kept", w, 6);
        rd_word(3, w);
        chk("R6 own update", w, 2);

        // R8: live flags
        mode = 1'b0; live = 8'hA5;
        @(negedge clk);
        chk("R8 live flags", int'(flag), 8'hA5);

        // R9/R3: saturation flag and value
        strobe_clr_all();
        mode = 1'b1; live = 8'hFF;
        pulse(7, 65534);
        chk("R9 flag below full scale", int'(flag), 0);
        pulse(7, 1);
        chk("R9 flag at full scale", int'(flag), 8'h80);
        pulse(7, 6);
        chk("R3 stays saturated flag", int'(flag), 8'h80);
        strobe_upd(7);
        rd_word(7, w);
        chk("R3 saturated snapshot", w, 65535);
        pulse(7, 65535);
        strobe_clr_all();
        chk("R4 global clear drops saturation", int'(flag), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule